// File: doc/BRIEF.md
# Power-Fail Retract and Brake Sequencer

This block decides when the head actuator and the spindle of a small disk drive must stop, and in which order. It has three shutdown causes. The first is a supply-low condition, built from two comparator flags with hysteresis between them. The second is the enable bit of the command word going to 0 (sleep). The third is an external forced-retract input held low. When any of them is present while the drive runs, both motor power stages are switched off and the head retract driver is switched on. A one-shot counter then holds this phase for a fixed number of clock cycles. When the count ends, the retract driver is released and every low-side driver of both motors is turned on to brake.

The block also drives an active-low fault flag. The flag is low while the supply is low, and during a power-on hold timer that restarts each time the supply recovers. In sleep, analog circuitry other than the supply monitor is powered down once braking has begun. The drive leaves brake and returns to running only when all of these hold: the enable bit is 1, the supply is good, the power-on hold has expired and the forced-retract input is high. On that return the spindle commutation logic is let out of its all-outputs-floating reset state. After power-up the block sits in sleep with the brake applied.

Asynchronous inputs (the two comparator flags and the forced-retract input) pass through a two-stage synchronizer. The enable bit comes from the serial shift register and is taken only on the single-cycle command-latch pulse.

Top module: `retract_brake_seq`

## Requirements
- R1: While reset is held, and after it is released, the outputs show sleep with brake applied: brake_o=1, power_en_o=0, retract_en_o=0, spindle_reset_o=1 and analog_off_o=1. The internal enable is 0 and fault_n_o is 0 until the supply is seen good.
- R2: The supply-low state sets when uv_trip_i is 1, and uv_trip_i wins if both flags are 1. It clears only when uv_trip_i=0 and uv_recover_i=1. With both flags at 0 it holds its value. A flag change takes effect 3 clock edges after it is applied.
- R3: fault_n_o is 0 while the supply is low, and for POR_CYCLES cycles after the supply-low state clears. Every new supply-low event restarts this hold.
- R4: enable_bit_i is taken only on a cycle with cmd_latch_i=1. Changing enable_bit_i without the latch pulse has no effect. A latched 0 starts retract on the second clock edge after the latch cycle.
- R5: A low on force_retract_n_i starts retract 3 clock edges after it is applied. A supply-low trigger starts retract one edge after fault_n_o falls.
- R6: During retract, power_en_o=0, retract_en_o=1, brake_o=0 and spindle_reset_o=1, for exactly RET_CYCLES clock cycles.
- R7: When retract ends, retract_en_o goes to 0 and brake_o goes to 1 on the same edge, with power_en_o staying 0.
- R8: A trigger that arrives during retract does not restart the count, and a cause that clears during retract does not end it early.
- R9: analog_off_o is 1 only while braking with the latched enable at 0.
- R10: From brake, the block returns to run one edge after the enable is latched 1, the supply is good, the power-on hold has expired and forced retract is released (all of them). On that edge spindle_reset_o falls together with the rise of power_en_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| uv_trip_i | input | 1 | Comparator flag: supply below the trip level |
| uv_recover_i | input | 1 | Comparator flag: supply above the trip level plus hysteresis margin |
| force_retract_n_i | input | 1 | External forced retract, active low |
| enable_bit_i | input | 1 | Enable/sleep bit from the command shift register (0 = sleep) |
| cmd_latch_i | input | 1 | Single-cycle pulse that applies the shifted command word |
| power_en_o | output | 1 | Spindle and actuator power stages enabled |
| retract_en_o | output | 1 | Head retract driver enabled |
| brake_o | output | 1 | All low-side drivers of both motors on |
| spindle_reset_o | output | 1 | Holds the spindle commutation logic in its all-floating reset state |
| analog_off_o | output | 1 | Power down of analog circuitry except the supply monitor |
| fault_n_o | output | 1 | Active-low fault flag |

## Verification
The bench times each retract phase edge by edge, for a sleep command, a forced retract and an undervoltage. A one-shot that is off by one, or that restarts on a second trigger, shows up as retract ending one cycle early or late, or being stretched. A one-cycle undervoltage glitch must still produce a full retract and a complete power-on hold. A monitor without hysteresis would release the fault while both comparator flags are low. A power-on timer that is not re-armed would let the drive run during the hold. The bench changes the enable bit without a latch pulse and expects no change. It also expects run to resume only after every condition is met: a sequencer that watched only the enable bit would re-enable power while the fault flag is still low.

// File: rtl/rbs_pkg.sv
package rbs_pkg;

  typedef enum logic [1:0] {
    SEQ_BRAKE   = 2'd0,
    SEQ_RETRACT = 2'd1,
    SEQ_RUN     = 2'd2
  } seq_state_e;

endpackage

// File: rtl/rbs_sync.sv
module rbs_sync #(
  parameter int              WIDTH   = 1,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= {STAGES{RST_VAL}};
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) begin
        stage_q[i] <= stage_q[i-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/rbs_uv_monitor.sv
module rbs_uv_monitor #(
  parameter int POR_CYCLES = 100_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trip_i,
  input  logic recover_i,
  output logic supply_low_o,
  output logic por_busy_o
);

  localparam int              PW       = (POR_CYCLES > 1) ? $clog2(POR_CYCLES) : 1;
  localparam logic [PW-1:0]   POR_LAST = PW'(POR_CYCLES - 1);

  logic          low_q, low_d;
  logic          busy_q, busy_d;
  logic [PW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  // Hysteresis latch: trip has priority, in-band holds
  always_comb begin
    low_d = low_q;
    if (trip_i)         low_d = 1'b1;
    else if (recover_i) low_d = 1'b0;
  end

  // Power-on hold: re-armed by any low supply, counts once supply is good
  assign cnt_en = low_q | busy_q;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (low_q) begin
      cnt_d  = '0;
      busy_d = 1'b1;
    end else if (busy_q) begin
      if (cnt_q == POR_LAST) busy_d = 1'b0;
      else                   cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q  <= 1'b1;
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else begin
      low_q <= low_d;
      if (cnt_en) begin
        cnt_q  <= cnt_d;
        busy_q <= busy_d;
      end
    end
  end

  assign supply_low_o = low_q;
  assign por_busy_o   = busy_q;

  p_trip_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    trip_i |=> supply_low_o);

  p_band_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!trip_i && !recover_i) |=> (supply_low_o == $past(supply_low_o)));

  p_hold_rearm_r3: assert property (@(posedge clk) disable iff (!rst_n)
    supply_low_o |=> por_busy_o);

endmodule

// File: rtl/rbs_oneshot.sv
module rbs_oneshot #(
  parameter int LEN = 1_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic done_o
);

  localparam int            CW   = (LEN > 1) ? $clog2(LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          at_end;

  assign at_end = (cnt_q == LAST);
  assign cnt_en = run_i | (cnt_q != '0);

  always_comb begin
    if (!run_i)      cnt_d = '0;
    else if (at_end) cnt_d = cnt_q;
    else             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done_o = run_i & at_end;

  // R8: once running, the count only advances; nothing reloads it mid-phase
  p_no_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !done_o) |=> (!run_i || cnt_q == CW'($past(cnt_q) + 1'b1)));

endmodule

// File: rtl/retract_brake_seq.sv
module retract_brake_seq
  import rbs_pkg::*;
#(
  parameter int RET_CYCLES  = 20_000_000,
  parameter int POR_CYCLES  = 100_000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic uv_trip_i,
  input  logic uv_recover_i,
  input  logic force_retract_n_i,
  input  logic enable_bit_i,
  input  logic cmd_latch_i,
  output logic power_en_o,
  output logic retract_en_o,
  output logic brake_o,
  output logic spindle_reset_o,
  output logic analog_off_o,
  output logic fault_n_o
);

  // Reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe_q;
  logic       core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign core_rst_n = rst_pipe_q[1];

  // Asynchronous inputs: {force_n, recover, trip}
  logic [2:0] async_s;
  logic       trip_s, recover_s, force_n_s;

  rbs_sync #(
    .WIDTH   (3),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (3'b100)
  ) u_sync (
    .clk   (clk),
    .rst_n (core_rst_n),
    .d_i   ({force_retract_n_i, uv_recover_i, uv_trip_i}),
    .q_o   (async_s)
  );
  assign {force_n_s, recover_s, trip_s} = async_s;

  logic supply_low, por_busy;

  rbs_uv_monitor #(
    .POR_CYCLES (POR_CYCLES)
  ) u_uv (
    .clk          (clk),
    .rst_n        (core_rst_n),
    .trip_i       (trip_s),
    .recover_i    (recover_s),
    .supply_low_o (supply_low),
    .por_busy_o   (por_busy)
  );

  // Enable bit: loaded only on the command-latch pulse, powers up as sleep
  logic en_q, en_load;
  assign en_load = cmd_latch_i;

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n)  en_q <= 1'b0;
    else if (en_load) en_q <= enable_bit_i;
  end

  // Sequencer
  seq_state_e state_q, state_d;
  logic       in_retract, ret_done;
  logic       shutdown_req, release_ok;

  assign shutdown_req = supply_low | ~force_n_s | ~en_q;
  assign release_ok   = ~shutdown_req & ~por_busy;
  assign in_retract   = (state_q == SEQ_RETRACT);

  rbs_oneshot #(
    .LEN (RET_CYCLES)
  ) u_oneshot (
    .clk    (clk),
    .rst_n  (core_rst_n),
    .run_i  (in_retract),
    .done_o (ret_done)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_RUN:     if (shutdown_req) state_d = SEQ_RETRACT;
      SEQ_RETRACT: if (ret_done)     state_d = SEQ_BRAKE;
      SEQ_BRAKE:   if (release_ok)   state_d = SEQ_RUN;
      default:                       state_d = SEQ_BRAKE;
    endcase
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) state_q <= SEQ_BRAKE;
    else             state_q <= state_d;
  end

  assign power_en_o      = (state_q == SEQ_RUN);
  assign retract_en_o    = in_retract;
  assign brake_o         = (state_q == SEQ_BRAKE);
  assign spindle_reset_o = (state_q != SEQ_RUN);
  assign analog_off_o    = brake_o & ~en_q;
  assign fault_n_o       = ~(supply_low | por_busy);

  p_enter_retract_r5: assert property (@(posedge clk) disable iff (!core_rst_n)
    (power_en_o && shutdown_req) |=> (retract_en_o && !power_en_o));

  p_retract_then_brake_r7: assert property (@(posedge clk) disable iff (!core_rst_n)
    (retract_en_o && ret_done) |=> (brake_o && !retract_en_o && !power_en_o));

  p_latch_only_r4: assert property (@(posedge clk) disable iff (!core_rst_n)
    !cmd_latch_i |=> $stable(en_q));

  p_run_gate_r10: assert property (@(posedge clk) disable iff (!core_rst_n)
    $rose(power_en_o) |-> ($past(en_q) && !$past(supply_low) && !$past(por_busy) && $past(brake_o)));

  p_floating_release_r10: assert property (@(posedge clk) disable iff (!core_rst_n)
    $fell(spindle_reset_o) |-> power_en_o);

endmodule

// File: tb/retract_brake_seq_test.sv
module retract_brake_seq_test;

  localparam int RET = 12;
  localparam int POR = 9;

  logic clk = 1'b0;
  logic rst_n;
  logic uv_trip, uv_recover, force_n, enable_bit, cmd_latch;
  logic power_en, retract_en, brake, spindle_reset, analog_off, fault_n;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  retract_brake_seq #(
    .RET_CYCLES (RET),
    .POR_CYCLES (POR)
  ) uut (
    .clk               (clk),
    .rst_n             (rst_n),
    .uv_trip_i         (uv_trip),
    .uv_recover_i      (uv_recover),
    .force_retract_n_i (force_n),
    .enable_bit_i      (enable_bit),
    .cmd_latch_i       (cmd_latch),
    .power_en_o        (power_en),
    .retract_en_o      (retract_en),
    .brake_o           (brake),
    .spindle_reset_o   (spindle_reset),
    .analog_off_o      (analog_off),
    .fault_n_o         (fault_n)
  );

  // Output vector order: power, retract, brake, spindle_reset, analog_off, fault_n
  localparam logic [5:0] RUN_OK      = 6'b100001;
  localparam logic [5:0] RUN_FLT     = 6'b100000;
  localparam logic [5:0] RET_OK      = 6'b010101;
  localparam logic [5:0] RET_FLT     = 6'b010100;
  localparam logic [5:0] BRK_SLEEP   = 6'b001111;
  localparam logic [5:0] BRK_SLP_FLT = 6'b001110;
  localparam logic [5:0] BRK_OK      = 6'b001101;
  localparam logic [5:0] BRK_FLT     = 6'b001100;

  task automatic chk(input string tag, input logic [5:0] exp);
    logic [5:0] act;
    act = {power_en, retract_en, brake, spindle_reset, analog_off, fault_n};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: pwr/ret/brk/sprst/aoff/fault_n actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; uv_trip = 1'b0; uv_recover = 1'b1; force_n = 1'b1;
    enable_bit = 1'b0; cmd_latch = 1'b0;
    edges(3);
    chk("R1 in reset", BRK_SLP_FLT);
    rst_n = 1'b1;
    edges(40);
    chk("R1 power-up sleep, R9 analog off", BRK_SLEEP);
  endtask

  task automatic t_wake;
    enable_bit = 1'b1; cmd_latch = 1'b1;
    edges(1);
    cmd_latch = 1'b0;
    chk("R10 enable latched, still braking", BRK_OK);
    edges(1);
    chk("R10 run resumes", RUN_OK);
  endtask

  task automatic t_no_latch;
    enable_bit = 1'b0;
    edges(6);
    chk("R4 enable change without latch ignored", RUN_OK);
  endtask

  task automatic t_sleep;
    enable_bit = 1'b0; cmd_latch = 1'b1;
    edges(1);
    cmd_latch = 1'b0;
    chk("R4 one edge after latch still running", RUN_OK);
    edges(1);
    chk("R4 R6 retract starts", RET_OK);
    edges(RET - 1);
    chk("R6 last retract cycle", RET_OK);
    edges(1);
    chk("R7 R9 sleep brake", BRK_SLEEP);
  endtask

  task automatic t_force;
    force_n = 1'b0;
    edges(2);
    chk("R5 force not yet through synchronizer", RUN_OK);
    edges(1);
    chk("R5 R6 forced retract", RET_OK);
    edges(RET - 1);
    chk("R6 forced retract length", RET_OK);
    edges(1);
    chk("R7 R9 brake without sleep", BRK_OK);
    edges(5);
    chk("R10 held in brake while forced", BRK_OK);
    force_n = 1'b1;
    edges(2);
    chk("R10 release not yet seen", BRK_OK);
    edges(1);
    chk("R10 run after force release", RUN_OK);
  endtask

  task automatic t_retrigger;
    force_n = 1'b0;
    edges(3);
    chk("R5 retract for retrigger test", RET_OK);
    force_n = 1'b1;
    edges(3);
    enable_bit = 1'b0; cmd_latch = 1'b1;
    edges(1);
    cmd_latch = 1'b0;
    chk("R8 new trigger during retract", RET_OK);
    edges(RET - 5);
    chk("R8 retract neither cut short nor restarted", RET_OK);
    edges(1);
    chk("R8 retract ends on original schedule", BRK_SLEEP);
  endtask

  task automatic t_uv;
    uv_trip = 1'b1; uv_recover = 1'b1;
    edges(2);
    chk("R2 trip still in synchronizer", RUN_OK);
    edges(1);
    chk("R2 R3 trip wins, fault low", RUN_FLT);
    uv_trip = 1'b0; uv_recover = 1'b0;
    edges(1);
    chk("R5 undervoltage retract", RET_FLT);
    edges(RET - 1);
    chk("R6 undervoltage retract length", RET_FLT);
    edges(1);
    chk("R7 brake after undervoltage", BRK_FLT);
    edges(10);
    chk("R2 in-band flags hold supply low", BRK_FLT);
    uv_recover = 1'b1;
    edges(2 + POR);
    chk("R3 power-on hold still running", BRK_FLT);
    edges(1);
    chk("R3 hold expired, fault released", BRK_OK);
    edges(1);
    chk("R10 run after hold", RUN_OK);
  endtask

  task automatic t_glitch;
    uv_trip = 1'b1; uv_recover = 1'b0;
    edges(1);
    uv_trip = 1'b0; uv_recover = 1'b1;
    edges(2);
    chk("R3 glitch sets fault", RUN_FLT);
    edges(1);
    chk("R5 glitch starts retract", RET_FLT);
    edges(POR - 1);
    chk("R3 hold rearmed after glitch", RET_FLT);
    edges(1);
    chk("R3 hold ends during retract", RET_OK);
    edges(RET - POR - 1);
    chk("R8 retract completes despite recovery", RET_OK);
    edges(1);
    chk("R7 brake after glitch retract", BRK_OK);
    edges(1);
    chk("R10 run after glitch", RUN_OK);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_wake();
    t_no_latch();
    t_sleep();
    t_wake();
    t_force();
    t_retrigger();
    t_wake();
    t_uv();
    t_glitch();
    finish_run();
  end

  initial begin
    repeat (20_000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
    end
  end

endmodule